// File: doc/BRIEF.md
# Input Protection Switch Sequencer

This block is the digital controller for a bidirectional pass switch that sits between an external power connector and a system supply rail. It reads two mode-select pins, five digital fault comparator outputs and a one-millisecond tick. From these it decides when the gate of the pass switch may be enabled, and when an active-low fault flag may be released. All pin and comparator inputs are first brought into the clock domain through two-flop synchronizers. The tick is assumed to already be a single-cycle pulse in the local clock domain.

The two mode pins select one of four behaviours:

- **Off:** the switch is held open, but faults are still reported.
- **Forward:** undervoltage and normal overvoltage lockouts guard the switch.
- **Boosted:** a raised overvoltage comparator replaces the normal one, and a high-resistance indication is raised while the switch conducts.
- **Backward:** the system battery powers an accessory. The voltage lockouts are disregarded, and an overcurrent comparator trips the switch. The switch retries after a rearm interval.

Closing is staged in two steps. The gate waits a programmable number of ticks after the lockouts clear. The flag is then released after a second programmable interval. A lockout fault opens the switch on the next state update and does not wait for any tick. A fault or a mode change during the wait restarts the sequence from zero.

Top module: `ovp_switch_ctrl`

## Requirements
- R1: With dir_i=1 and rev_i=1 (off mode), gate_en_o stays 0. In this mode flag_n_o equals the inverse of (uv_i | ov_i | ot_i), so the dir_i level does not mask faults.
- R2: With dir_i=0 and rev_i=1 (forward mode), the lockout fault is uv_i | ov_i | ot_i, and ovh_i and ocp_i have no effect. The gate only closes when this fault is clear.
- R3: With dir_i=0 and rev_i=0 (boosted mode), the lockout fault is uv_i | ovh_i | ot_i, and ov_i is ignored. hi_res_o is 1 exactly while gate_en_o is 1 in this mode.
- R4: With dir_i=1 and rev_i=0 (backward mode), uv_i, ov_i and ovh_i are ignored. The lockout fault is ot_i alone, and ocp_i acts as the overcurrent trip.
- R5: In every mode except off, gate_en_o rises on the clock edge of the START_TICKS-th tick counted after the sequencer leaves its idle state.
- R6: flag_n_o rises on the clock edge of the FLAG_TICKS-th tick counted after gate_en_o rose, and stays 0 before that.
- R7: flag_n_o is 0 whenever the mode's lockout fault is present. In backward mode it is also 0 while ocp_i is high or a trip is pending.
- R8: A change of a fault input reaches gate_en_o on the third rising clock edge after it is applied (two synchronizer stages plus the state register), with no tick needed. flag_n_o falls one edge earlier.
- R9: A lockout fault or a mode change while waiting for the gate clears the wait. A full START_TICKS ticks are then needed again.
- R10: In backward mode, ocp_i opens the switch and holds it open for REARM_TICKS ticks. After that the sequence restarts, and the gate closes again after START_TICKS further ticks.
- R11: While rst_n is low, gate_en_o, hi_res_o and flag_n_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms_i | input | 1 | One-cycle pulse per millisecond, in the clk domain |
| dir_i | input | 1 | Mode pin A (asynchronous) |
| rev_i | input | 1 | Mode pin B (asynchronous) |
| uv_i | input | 1 | 1 when the input is below the undervoltage threshold |
| ov_i | input | 1 | 1 when the input is above the normal overvoltage threshold |
| ovh_i | input | 1 | 1 when the input is above the raised overvoltage threshold |
| ocp_i | input | 1 | 1 when the backward current exceeds the limit |
| ot_i | input | 1 | 1 when overtemperature is signalled |
| gate_en_o | output | 1 | Pass switch gate enable |
| hi_res_o | output | 1 | High-resistance indication for boosted mode |
| flag_n_o | output | 1 | Active-low fault flag (models the open-drain output) |

## Verification
The bench builds the block with START_TICKS=4, FLAG_TICKS=3 and REARM_TICKS=2. With these values every staged delay fits into a handful of ticks. This lets directed cases probe the exact tick on which the gate and the flag change, the restart after an aborted wait, and the rearm after a trip. It also lets each random trial run a full closing sequence in every mode. The synchronizer depth is not a parameter, so the three-edge fault latency is checked edge by edge just as the block has it.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

  typedef enum logic [1:0] {
    MD_BOOST = 2'b00,  // dir=0 rev=0
    MD_FWD   = 2'b01,  // dir=0 rev=1
    MD_BACK  = 2'b10,  // dir=1 rev=0
    MD_OFF   = 2'b11   // dir=1 rev=1
  } mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_WAIT  = 3'd1,
    SQ_ON    = 3'd2,
    SQ_RUN   = 3'd3,
    SQ_TRIP  = 3'd4
  } seq_e;

  function automatic mode_e pins_to_mode(input logic dir, input logic rev);
    return mode_e'({dir, rev});
  endfunction

  // Lockout fault for one mode; overcurrent is handled by the sequencer.
  function automatic logic lockout(input mode_e m, input logic uv, input logic ov,
                                   input logic ovh, input logic ot);
    logic f;
    unique case (m)
      MD_FWD:   f = uv | ov  | ot;
      MD_BOOST: f = uv | ovh | ot;
      MD_BACK:  f = ot;
      default:  f = uv | ov  | ot;
    endcase
    return f;
  endfunction

  // True when the running count has reached its last step.
  function automatic logic last_step(input int unsigned cnt, input int unsigned lim);
    return cnt == lim - 1;
  endfunction

endpackage

// File: rtl/ovp_sync.sv
module ovp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        stab_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= d_i[i];
        stab_q[i] <= meta_q[i];
      end
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/ovp_mode_eval.sv
module ovp_mode_eval
  import ovp_pkg::*;
(
  input  logic  dir_s,
  input  logic  rev_s,
  input  logic  uv_s,
  input  logic  ov_s,
  input  logic  ovh_s,
  input  logic  ocp_s,
  input  logic  ot_s,
  output mode_e mode_o,
  output logic  lock_fault_o,
  output logic  ocp_live_o
);
  assign mode_o       = pins_to_mode(dir_s, rev_s);
  assign lock_fault_o = lockout(mode_o, uv_s, ov_s, ovh_s, ot_s);
  // Overcurrent only matters while power flows backward.
  assign ocp_live_o   = (mode_o == MD_BACK) && ocp_s;
endmodule

// File: rtl/ovp_seq.sv
module ovp_seq
  import ovp_pkg::*;
#(
  parameter int START_TICKS = 30,
  parameter int FLAG_TICKS  = 30,
  parameter int REARM_TICKS = 5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  input  mode_e mode_i,
  input  logic  lock_fault_i,
  input  logic  ocp_live_i,
  output logic  gate_o,
  output logic  run_o,
  output logic  trip_o,
  output logic  mode_chg_o
);
  localparam int MAXT  = (START_TICKS > FLAG_TICKS)
                         ? ((START_TICKS > REARM_TICKS) ? START_TICKS : REARM_TICKS)
                         : ((FLAG_TICKS > REARM_TICKS) ? FLAG_TICKS : REARM_TICKS);
  localparam int CNT_W = $clog2(MAXT + 1);

  seq_e             state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  mode_e            mode_q;
  logic             cnt_done;
  int unsigned      cur_lim;

  assign mode_chg_o = (mode_i != mode_q);

  always_comb begin
    unique case (state_q)
      SQ_WAIT: cur_lim = START_TICKS;
      SQ_ON:   cur_lim = FLAG_TICKS;
      SQ_TRIP: cur_lim = REARM_TICKS;
      default: cur_lim = 1;
    endcase
    cnt_done = tick_i && last_step(int'(cnt_q), cur_lim);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (mode_chg_o || mode_i == MD_OFF || lock_fault_i) begin
      state_d = SQ_IDLE;
      cnt_d   = '0;
    end else if (ocp_live_i && state_q != SQ_TRIP) begin
      state_d = SQ_TRIP;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          state_d = SQ_WAIT;
          cnt_d   = '0;
        end
        SQ_WAIT: if (tick_i) begin
          if (cnt_done) begin
            state_d = SQ_ON;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        SQ_ON: if (tick_i) begin
          if (cnt_done) begin
            state_d = SQ_RUN;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        SQ_TRIP: if (tick_i) begin
          if (cnt_done) begin
            state_d = SQ_IDLE;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: begin
          state_d = state_q;
          cnt_d   = cnt_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      mode_q  <= MD_BOOST;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_i;
    end
  end

  assign gate_o = (state_q == SQ_ON) || (state_q == SQ_RUN);
  assign run_o  = (state_q == SQ_RUN);
  assign trip_o = (state_q == SQ_TRIP);

  // R1: off mode forces the gate open on the next edge
  a_r1_off_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_OFF) |=> !gate_o);

  // R8: a lockout fault opens the gate on the next edge without a tick
  a_r8_fault_opens: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fault_i |=> !gate_o);

  // R5: the gate only closes after waiting out the start count
  a_r5_close_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> ($past(state_q) == SQ_WAIT) && $past(tick_i));

  // R9: an aborted wait returns to idle with a cleared count
  a_r9_wait_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_WAIT && (lock_fault_i || mode_chg_o)) |=> (state_q == SQ_IDLE && cnt_q == '0));

  // R10: backward overcurrent on a closed switch leads to the trip state
  a_r10_trip_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && ocp_live_i && !lock_fault_i && !mode_chg_o) |=> (trip_o && !gate_o));

  // R10: leaving the trip state is only possible on a tick or an abort
  a_r10_trip_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_o && !tick_i && !lock_fault_i && !mode_chg_o && mode_i != MD_OFF) |=> trip_o);

endmodule

// File: rtl/ovp_switch_ctrl.sv
module ovp_switch_ctrl
  import ovp_pkg::*;
#(
  parameter int START_TICKS = 30,
  parameter int FLAG_TICKS  = 30,
  parameter int REARM_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms_i,
  input  logic dir_i,
  input  logic rev_i,
  input  logic uv_i,
  input  logic ov_i,
  input  logic ovh_i,
  input  logic ocp_i,
  input  logic ot_i,
  output logic gate_en_o,
  output logic hi_res_o,
  output logic flag_n_o
);
  localparam int NSYNC = 7;

  logic [NSYNC-1:0] raw_vec, syn_vec;
  mode_e mode;
  logic  lock_fault, ocp_live;
  logic  gate, run, trip, mode_chg;
  logic  alarm;

  assign raw_vec = {dir_i, rev_i, uv_i, ov_i, ovh_i, ocp_i, ot_i};

  ovp_sync #(.W(NSYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_vec),
    .q_o   (syn_vec)
  );

  ovp_mode_eval u_eval (
    .dir_s        (syn_vec[6]),
    .rev_s        (syn_vec[5]),
    .uv_s         (syn_vec[4]),
    .ov_s         (syn_vec[3]),
    .ovh_s        (syn_vec[2]),
    .ocp_s        (syn_vec[1]),
    .ot_s         (syn_vec[0]),
    .mode_o       (mode),
    .lock_fault_o (lock_fault),
    .ocp_live_o   (ocp_live)
  );

  ovp_seq #(
    .START_TICKS (START_TICKS),
    .FLAG_TICKS  (FLAG_TICKS),
    .REARM_TICKS (REARM_TICKS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_ms_i),
    .mode_i       (mode),
    .lock_fault_i (lock_fault),
    .ocp_live_i   (ocp_live),
    .gate_o       (gate),
    .run_o        (run),
    .trip_o       (trip),
    .mode_chg_o   (mode_chg)
  );

  assign alarm     = lock_fault | ocp_live | trip;
  assign gate_en_o = gate;
  assign hi_res_o  = gate && (mode == MD_BOOST);
  assign flag_n_o  = rst_n && ((mode == MD_OFF) ? !lock_fault
                                                : (run && !alarm && !mode_chg));

  // R7: an active alarm always pulls the flag low
  a_r7_flag_on_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> !flag_n_o);

  // R6: outside off mode a released flag implies a closed switch
  a_r6_flag_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_n_o && mode != MD_OFF) |-> gate_en_o);

  // R3: the high-resistance indication only accompanies a closed switch
  a_r3_hires_gate: assert property (@(posedge clk) disable iff (!rst_n)
    hi_res_o |-> gate_en_o);

endmodule

// File: tb/ovp_switch_ctrl_tb.sv
module ovp_switch_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ST = 4;
  localparam int FT = 3;
  localparam int RT = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, dir, rev, uv, ov, ovh, ocp, ot;
  logic gate, hires, flag_n;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ovp_switch_ctrl #(.START_TICKS(ST), .FLAG_TICKS(FT), .REARM_TICKS(RT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms_i(tick), .dir_i(dir), .rev_i(rev),
    .uv_i(uv), .ov_i(ov), .ovh_i(ovh), .ocp_i(ocp), .ot_i(ot),
    .gate_en_o(gate), .hi_res_o(hires), .flag_n_o(flag_n)
  );

  // Expected lockout written per pin pair.
  function automatic logic exp_fault(logic d, logic r, logic u, logic o, logic oh, logic t);
    if (d && !r) return t;
    if (!d && !r) return u || oh || t;
    return u || o || t;
  endfunction

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 0; dir = 0; rev = 1; uv = 0; ov = 0; ovh = 0; ocp = 0; ot = 0;
    repeat (3) @(negedge clk);
    chk("R11 gate", gate, 1'b0);
    chk("R11 flag", flag_n, 1'b0);
    chk("R11 hires", hires, 1'b0);
    rst_n = 1'b1;
    settle();

    // R5 / R6: staged closing in forward mode
    ticks(ST - 1);
    chk("R5 gate before last tick", gate, 1'b0);
    ticks(1);
    chk("R5 gate on last tick", gate, 1'b1);
    chk("R6 flag held after gate", flag_n, 1'b0);
    ticks(FT - 1);
    chk("R6 flag before last tick", flag_n, 1'b0);
    ticks(1);
    chk("R6 flag released", flag_n, 1'b1);

    // R2: raised comparator has no effect in forward mode
    ovh = 1'b1;
    settle();
    chk("R2 ovh ignored gate", gate, 1'b1);
    ovh = 1'b0;

    // R8: exact latency of an overvoltage
    ov = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R8 gate still on after two edges", gate, 1'b1);
    chk("R8 flag low after two edges", flag_n, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 gate off on third edge", gate, 1'b0);
    ov = 1'b0;
    settle();

    // R9: fault during the wait restarts the count
    ticks(2);
    uv = 1'b1;
    settle();
    chk("R7 flag on uv", flag_n, 1'b0);
    uv = 1'b0;
    settle();
    ticks(ST - 1);
    chk("R9 wait restarted", gate, 1'b0);
    ticks(1);
    chk("R9 gate after full wait", gate, 1'b1);
    ticks(FT);

    // R3: boosted mode
    rev = 1'b0; ov = 1'b1;
    settle();
    ticks(ST);
    chk("R3 gate with ov high", gate, 1'b1);
    chk("R3 hires", hires, 1'b1);
    ovh = 1'b1;
    settle();
    chk("R3 ovh opens", gate, 1'b0);
    chk("R3 hires drops", hires, 1'b0);
    chk("R7 flag on ovh", flag_n, 1'b0);
    ovh = 1'b0; ov = 1'b0;
    settle();

    // R4: backward mode ignores voltage lockouts
    dir = 1'b1; rev = 1'b0; uv = 1'b1; ov = 1'b1; ovh = 1'b1;
    settle();
    ticks(ST + FT);
    chk("R4 gate", gate, 1'b1);
    chk("R4 flag", flag_n, 1'b1);
    chk("R4 hires", hires, 1'b0);

    // R10: overcurrent trip and rearm
    ocp = 1'b1;
    settle();
    chk("R10 trip opens", gate, 1'b0);
    chk("R7 flag on ocp", flag_n, 1'b0);
    ocp = 1'b0;
    settle();
    chk("R7 flag during rearm", flag_n, 1'b0);
    ticks(RT - 1);
    chk("R10 still open", gate, 1'b0);
    ticks(1);
    settle();
    ticks(ST - 1);
    chk("R10 not before start count", gate, 1'b0);
    ticks(1);
    chk("R10 closed after rearm", gate, 1'b1);
    ticks(FT);

    // R7: overtemperature in backward mode
    ot = 1'b1;
    settle();
    chk("R7 ot flag", flag_n, 1'b0);
    chk("R7 ot gate", gate, 1'b0);
    ot = 1'b0;

    // R1: off mode
    rev = 1'b1; uv = 1'b0; ov = 1'b0; ovh = 1'b0;
    settle();
    ticks(ST + FT);
    chk("R1 gate off", gate, 1'b0);
    chk("R1 flag clear", flag_n, 1'b1);
    uv = 1'b1;
    settle();
    chk("R1 fault not masked", flag_n, 1'b0);
    uv = 1'b0;
    settle();

    // Random trials, steady inputs then a full closing sequence
    begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(1234);
    end
    for (int t = 0; t < 40; t++) begin
      logic f, off_m;
      dir = 1'($urandom); rev = 1'($urandom);
      uv  = ($urandom % 4) == 0; ov = ($urandom % 4) == 0;
      ovh = ($urandom % 4) == 0; ot = ($urandom % 6) == 0; ocp = 1'b0;
      settle();
      ticks(ST + FT);
      f     = exp_fault(dir, rev, uv, ov, ovh, ot);
      off_m = dir && rev;
      chk("R2 random gate", gate, !off_m && !f);
      chk("R7 random flag", flag_n, !f);
      chk("R3 random hires", hires, !dir && !rev && !f);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule